// File: doc/BRIEF.md
# Static-Call Frame Builder

This block manages method frames in the data memory of a single-threaded stack processor whose code is linked statically. When a static call is issued, it reads a two-byte header at the target method's entry point: the number of parameter words, then the number of additional local words. From these counts and the caller's stack pointer it lays out the new frame. The parameters the caller has already pushed become the first locals. The extra locals follow them. Two words of return information come next, the caller's return PC and then the caller's frame base. The operand stack grows from the word after those two. The block writes the two return words and reports the new stack pointer, frame base and program counter.

On a return, the block reads the current method's header again to find the return words. It restores the caller's PC and frame base, and it drops the frame together with the parameters. On a value-returning return, it first reads the callee's top-of-stack word. It then stores that word at the caller's restored stack top. The stack is word-addressed and grows upward, and the stack pointer addresses the next free word. A call that would run past a configured stack limit is refused, and nothing is written. Program memory is reached through a byte-wide request/acknowledge read port. Data memory is reached through one word-wide request/acknowledge port.

Top module: `fa_frame_unit`

## Requirements
- R1: After reset, op_ready is 1 and done, ovf, pm_req, dm_req, res_sp, res_fp and res_pc are all 0.
- R2: Any accepted operation first reads the program byte at meth_addr (parameter count P), then the byte at meth_addr+1 (extra local count L). When these two reads finish, the program port goes idle.
- R3: A call (op_kind 2'b01) that does not overflow reports res_fp = cur_sp − P, res_sp = cur_sp + L + 2 and res_pc = meth_addr + 2, with ovf = 0.
- R4: That call writes ret_pc, zero-extended, to data word res_fp + P + L, and writes cur_fp, zero-extended, to the next word.
- R5: A call whose new stack pointer (cur_sp + L + 2) exceeds STACK_LIMIT, or whose P exceeds cur_sp, reports ovf = 1. It makes no data memory write and reports res_sp = cur_sp, res_fp = cur_fp and res_pc = ret_pc. A new stack pointer equal to STACK_LIMIT is accepted.
- R6: A return (op_kind 2'b10) treats meth_addr as the current method. It reads word cur_fp + P + L as the PC and the following word as the frame base. It reports res_pc = that PC, res_fp = that frame base and res_sp = cur_fp, with ovf = 0.
- R7: A value return (op_kind 2'b11) reads word cur_sp − 1 before it removes the frame. It writes that value to word cur_fp and reports res_sp = cur_fp + 1. Its other results are as in R6.
- R8: A memory request holds its address, write enable and write data unchanged until it is acknowledged. pm_req and dm_req are never high together.
- R9: An operation is accepted on a clock edge where op_valid and op_ready are both high. op_ready then stays low until done. done is a one-cycle pulse, and the results are valid during it.
- R10: op_valid with op_kind 2'b00 is ignored. op_ready stays high, no memory request is made, done is not raised and the results keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_kind | input | 2 | 01 call, 10 return, 11 value return, 00 none |
| op_ready | output | 1 | Unit idle and able to accept an operation |
| meth_addr | input | PW | Call target or current method entry address |
| ret_pc | input | PW | Caller's resume address (call only) |
| cur_sp | input | AW | Current stack pointer (next free word) |
| cur_fp | input | AW | Current frame base |
| pm_req | output | 1 | Program memory read request |
| pm_addr | output | PW | Program memory byte address |
| pm_ack | input | 1 | Program memory acknowledge, data valid |
| pm_rdata | input | 8 | Program memory read byte |
| dm_req | output | 1 | Data memory request |
| dm_we | output | 1 | Data memory write enable |
| dm_addr | output | AW | Data memory word address |
| dm_wdata | output | DW | Data memory write word |
| dm_ack | input | 1 | Data memory acknowledge, read data valid |
| dm_rdata | input | DW | Data memory read word |
| done | output | 1 | Operation complete (one cycle) |
| ovf | output | 1 | Last call refused for stack overflow |
| res_sp | output | AW | Resulting stack pointer |
| res_fp | output | AW | Resulting frame base |
| res_pc | output | PW | Resulting program counter |

## Verification
A wrong header count or a wrong frame base shows up in two places. It moves the return-word addresses, which the bench sees in its memory model as soon as the call finishes. A matching return on the same stack then brings back the wrong PC or frame base, so a fault that leaves the call's own results looking right is still exposed within one call/return pair. A broken overflow check shows up as writes or changed results on exactly the boundary call, one word past the limit. Losing the top-of-stack value before teardown shows up at once as a wrong word at the caller's stack top.

// File: rtl/fa_pkg.sv
package fa_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_CALL = 2'b01,
    OP_RET  = 2'b10,
    OP_IRET = 2'b11
  } fa_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HDR,
    S_PLAN,
    S_WPC,
    S_WFP,
    S_RTOP,
    S_RPC,
    S_RFP,
    S_WRES,
    S_DONE
  } fa_state_e;

  localparam int HDR_BYTES = 2;

endpackage

// File: rtl/fa_hdr_fetch.sv
module fa_hdr_fetch #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] base,
  output logic          pm_req,
  output logic [PW-1:0] pm_addr,
  input  logic          pm_ack,
  input  logic [7:0]    pm_rdata,
  output logic          hdr_done,
  output logic [7:0]    n_param,
  output logic [7:0]    n_local
);
  import fa_pkg::*;

  localparam int IW = 1;

  logic [PW-1:0] base_q;
  logic [IW-1:0] idx_q;
  logic          active_q;
  logic          last_byte;

  assign last_byte = (idx_q == IW'(HDR_BYTES - 1));
  assign pm_req    = active_q;
  assign pm_addr   = base_q + PW'(idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      hdr_done <= 1'b0;
    end else begin
      hdr_done <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        base_q   <= base;
      end else if (active_q && pm_ack) begin
        if (last_byte) begin
          active_q <= 1'b0;
          hdr_done <= 1'b1;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  // one capture register per header byte, selected by its position
  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_field
    logic [7:0] f_q;
    always_ff @(posedge clk) begin
      if (!rst_n) f_q <= '0;
      else if (active_q && pm_ack && idx_q == IW'(g)) f_q <= pm_rdata;
    end
  end

  assign n_param = g_field[0].f_q;
  assign n_local = g_field[1].f_q;

endmodule

// File: rtl/fa_layout.sv
module fa_layout #(
  parameter int AW          = 10,
  parameter int STACK_LIMIT = 1000
) (
  input  logic          is_call,
  input  logic          is_iret,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] fp,
  input  logic [7:0]    n_param,
  input  logic [7:0]    n_local,
  output logic [AW-1:0] frame_base,
  output logic [AW-1:0] info_addr,
  output logic [AW-1:0] next_sp,
  output logic          overflow
);
  localparam int            EW      = AW + 1;
  localparam logic [EW-1:0] LIMIT_W = EW'(STACK_LIMIT);

  function automatic logic [EW-1:0] wide_addr(input logic [AW-1:0] v);
    return {1'b0, v};
  endfunction

  function automatic logic [EW-1:0] wide_cnt(input logic [7:0] v);
    return EW'(v);
  endfunction

  // base of the new frame: pushed parameters become the first locals
  function automatic logic [EW-1:0] call_base(input logic [AW-1:0] s, input logic [7:0] p);
    return wide_addr(s) - wide_cnt(p);
  endfunction

  // return words sit right above parameters and locals
  function automatic logic [EW-1:0] ret_words(input logic [EW-1:0] b, input logic [7:0] p,
                                              input logic [7:0] l);
    return b + wide_cnt(p) + wide_cnt(l);
  endfunction

  logic [EW-1:0] base_w, info_w, top_w;

  always_comb begin
    base_w = is_call ? call_base(sp, n_param) : wide_addr(fp);
    info_w = ret_words(base_w, n_param, n_local);
    if (is_call) top_w = info_w + EW'(2);
    else         top_w = wide_addr(fp) + EW'(is_iret);
    overflow = is_call && (base_w[AW] || (top_w > LIMIT_W));
  end

  assign frame_base = base_w[AW-1:0];
  assign info_addr  = info_w[AW-1:0];
  assign next_sp    = top_w[AW-1:0];

endmodule

// File: rtl/fa_frame_unit.sv
module fa_frame_unit #(
  parameter int DW          = 16,
  parameter int AW          = 10,
  parameter int PW          = 12,
  parameter int STACK_LIMIT = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  output logic          op_ready,
  input  logic [PW-1:0] meth_addr,
  input  logic [PW-1:0] ret_pc,
  input  logic [AW-1:0] cur_sp,
  input  logic [AW-1:0] cur_fp,
  output logic          pm_req,
  output logic [PW-1:0] pm_addr,
  input  logic          pm_ack,
  input  logic [7:0]    pm_rdata,
  output logic          dm_req,
  output logic          dm_we,
  output logic [AW-1:0] dm_addr,
  output logic [DW-1:0] dm_wdata,
  input  logic          dm_ack,
  input  logic [DW-1:0] dm_rdata,
  output logic          done,
  output logic          ovf,
  output logic [AW-1:0] res_sp,
  output logic [AW-1:0] res_fp,
  output logic [PW-1:0] res_pc
);
  import fa_pkg::*;

  fa_state_e     state;
  fa_op_e        op_q;
  logic [PW-1:0] meth_q, rpc_q, pc_rd_q;
  logic [AW-1:0] sp_q, fp_q;
  logic [AW-1:0] info_q, base_q, next_q;
  logic [DW-1:0] top_q;
  logic          ovf_q;

  // named internal events
  logic          accept;
  logic          hdr_start;
  logic          hdr_done;
  logic [7:0]    n_param, n_local;
  logic          plan_ovf;
  logic [AW-1:0] plan_base, plan_info, plan_next;
  logic          is_call, is_iret;
  logic          dm_fire;

  assign accept    = op_valid && op_ready && (op_kind != OP_NONE);
  assign hdr_start = accept;
  assign is_call   = (op_q == OP_CALL);
  assign is_iret   = (op_q == OP_IRET);
  assign dm_fire   = dm_req && dm_ack;
  assign op_ready  = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign ovf       = ovf_q;

  fa_hdr_fetch #(.PW(PW)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (hdr_start),
    .base     (meth_addr),
    .pm_req   (pm_req),
    .pm_addr  (pm_addr),
    .pm_ack   (pm_ack),
    .pm_rdata (pm_rdata),
    .hdr_done (hdr_done),
    .n_param  (n_param),
    .n_local  (n_local)
  );

  fa_layout #(.AW(AW), .STACK_LIMIT(STACK_LIMIT)) u_layout (
    .is_call    (is_call),
    .is_iret    (is_iret),
    .sp         (sp_q),
    .fp         (fp_q),
    .n_param    (n_param),
    .n_local    (n_local),
    .frame_base (plan_base),
    .info_addr  (plan_info),
    .next_sp    (plan_next),
    .overflow   (plan_ovf)
  );

  always_comb begin
    dm_req   = 1'b0;
    dm_we    = 1'b0;
    dm_addr  = info_q;
    dm_wdata = '0;
    case (state)
      S_WPC:  begin dm_req = 1'b1; dm_we = 1'b1; dm_wdata = DW'(rpc_q); end
      S_WFP:  begin dm_req = 1'b1; dm_we = 1'b1; dm_addr = info_q + AW'(1); dm_wdata = DW'(fp_q); end
      S_RTOP: begin dm_req = 1'b1; dm_addr = sp_q - AW'(1); end
      S_RPC:  begin dm_req = 1'b1; end
      S_RFP:  begin dm_req = 1'b1; dm_addr = info_q + AW'(1); end
      S_WRES: begin dm_req = 1'b1; dm_we = 1'b1; dm_addr = fp_q; dm_wdata = top_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_NONE;
      meth_q  <= '0;
      rpc_q   <= '0;
      sp_q    <= '0;
      fp_q    <= '0;
      info_q  <= '0;
      base_q  <= '0;
      next_q  <= '0;
      top_q   <= '0;
      pc_rd_q <= '0;
      ovf_q   <= 1'b0;
      res_sp  <= '0;
      res_fp  <= '0;
      res_pc  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op_q   <= fa_op_e'(op_kind);
          meth_q <= meth_addr;
          rpc_q  <= ret_pc;
          sp_q   <= cur_sp;
          fp_q   <= cur_fp;
          state  <= S_HDR;
        end
        S_HDR: if (hdr_done) state <= S_PLAN;
        S_PLAN: begin
          info_q <= plan_info;
          base_q <= plan_base;
          next_q <= plan_next;
          ovf_q  <= plan_ovf;
          if (is_call) begin
            if (plan_ovf) begin
              res_sp <= sp_q;
              res_fp <= fp_q;
              res_pc <= rpc_q;
              state  <= S_DONE;
            end else begin
              state <= S_WPC;
            end
          end else if (is_iret) begin
            state <= S_RTOP;
          end else begin
            state <= S_RPC;
          end
        end
        S_WPC: if (dm_fire) state <= S_WFP;
        S_WFP: if (dm_fire) begin
          res_sp <= next_q;
          res_fp <= base_q;
          res_pc <= meth_q + PW'(HDR_BYTES);
          state  <= S_DONE;
        end
        S_RTOP: if (dm_fire) begin
          top_q <= dm_rdata;
          state <= S_RPC;
        end
        S_RPC: if (dm_fire) begin
          pc_rd_q <= dm_rdata[PW-1:0];
          state   <= S_RFP;
        end
        S_RFP: if (dm_fire) begin
          res_pc <= pc_rd_q;
          res_fp <= dm_rdata[AW-1:0];
          res_sp <= next_q;
          state  <= is_iret ? S_WRES : S_DONE;
        end
        S_WRES: if (dm_fire) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fa_frame_unit_chk.sv
module fa_frame_unit_chk #(
  parameter int DW = 16,
  parameter int AW = 10,
  parameter int PW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [1:0]    op_kind,
  input logic          op_ready,
  input logic          pm_req,
  input logic [PW-1:0] pm_addr,
  input logic          pm_ack,
  input logic          dm_req,
  input logic          dm_we,
  input logic [AW-1:0] dm_addr,
  input logic [DW-1:0] dm_wdata,
  input logic          dm_ack,
  input logic          done,
  input logic          ovf,
  input logic          hdr_done
);

  // R8: only one memory port is used at a time
  a_r8_single_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_req && dm_req));

  // R8: data request held stable until acknowledged
  a_r8_dm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req && !dm_ack) |=> (dm_req && $stable(dm_addr) && $stable(dm_we) && $stable(dm_wdata)));

  // R8: program request held stable until acknowledged
  a_r8_pm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_req && !pm_ack) |=> (pm_req && $stable(pm_addr)));

  // R2: program port released once both header bytes are in
  a_r2_hdr_release: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |-> !pm_req);

  // R5: a refused call never writes data memory
  a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !(dm_req && dm_we));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: busy after acceptance
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_kind != 2'b00) |=> !op_ready);

  // R10: the empty operation code starts nothing
  a_r10_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_kind == 2'b00) |=> (op_ready && !pm_req && !dm_req));

endmodule

bind fa_frame_unit fa_frame_unit_chk #(.DW(DW), .AW(AW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_kind  (op_kind),
  .op_ready (op_ready),
  .pm_req   (pm_req),
  .pm_addr  (pm_addr),
  .pm_ack   (pm_ack),
  .dm_req   (dm_req),
  .dm_we    (dm_we),
  .dm_addr  (dm_addr),
  .dm_wdata (dm_wdata),
  .dm_ack   (dm_ack),
  .done     (done),
  .ovf      (ovf),
  .hdr_done (hdr_done)
);

// File: tb/tb_fa_frame_unit.sv
module tb_fa_frame_unit;
  localparam int DW = 16, AW = 10, PW = 12, LIM = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          op_valid = 1'b0;
  logic [1:0]    op_kind = 2'b00;
  logic          op_ready;
  logic [PW-1:0] meth_addr = '0, ret_pc = '0;
  logic [AW-1:0] cur_sp = '0, cur_fp = '0;
  logic          pm_req, pm_ack;
  logic [PW-1:0] pm_addr;
  logic [7:0]    pm_rdata;
  logic          dm_req, dm_we, dm_ack;
  logic [AW-1:0] dm_addr;
  logic [DW-1:0] dm_wdata, dm_rdata;
  logic          done, ovf;
  logic [AW-1:0] res_sp, res_fp;
  logic [PW-1:0] res_pc;

  fa_frame_unit #(.DW(DW), .AW(AW), .PW(PW), .STACK_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_ready(op_ready),
    .meth_addr(meth_addr), .ret_pc(ret_pc), .cur_sp(cur_sp), .cur_fp(cur_fp),
    .pm_req(pm_req), .pm_addr(pm_addr), .pm_ack(pm_ack), .pm_rdata(pm_rdata),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_ack(dm_ack), .dm_rdata(dm_rdata), .done(done), .ovf(ovf),
    .res_sp(res_sp), .res_fp(res_fp), .res_pc(res_pc)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [DW-1:0] dmem [0:(1<<AW)-1];
  logic [7:0]    pmem [0:(1<<PW)-1];
  int dm_wr_cnt = 0, pm_wait = 0, dm_wait = 0;
  int hold_viol = 0, dual_viol = 0;
  logic          pm_pend = 1'b0, dm_pend = 1'b0;
  logic [PW-1:0] pm_addr_l = '0;
  logic [AW-1:0] dm_addr_l = '0;
  logic [DW-1:0] dm_wdata_l = '0;
  logic          dm_we_l = 1'b0;

  // memory models with random latency; also watch the request rules (R8)
  always @(posedge clk) begin
    if (!rst_n) begin
      pm_ack <= 1'b0; dm_ack <= 1'b0; pm_wait <= 0; dm_wait <= 0;
      pm_pend <= 1'b0; dm_pend <= 1'b0;
    end else begin
      if (pm_req && dm_req) dual_viol <= dual_viol + 1;
      if (pm_pend && (!pm_req || pm_addr != pm_addr_l)) hold_viol <= hold_viol + 1;
      if (dm_pend && (!dm_req || dm_addr != dm_addr_l || dm_we != dm_we_l ||
                      dm_wdata != dm_wdata_l)) hold_viol <= hold_viol + 1;
      pm_pend <= pm_req && !pm_ack; pm_addr_l <= pm_addr;
      dm_pend <= dm_req && !dm_ack; dm_addr_l <= dm_addr;
      dm_we_l <= dm_we; dm_wdata_l <= dm_wdata;
      if (pm_ack) pm_ack <= 1'b0;
      else if (pm_req) begin
        if (pm_wait == 0) begin
          pm_ack <= 1'b1; pm_rdata <= pmem[pm_addr]; pm_wait <= $urandom_range(0, 2);
        end else pm_wait <= pm_wait - 1;
      end
      if (dm_ack) dm_ack <= 1'b0;
      else if (dm_req) begin
        if (dm_wait == 0) begin
          dm_ack <= 1'b1; dm_rdata <= dmem[dm_addr]; dm_wait <= $urandom_range(0, 2);
          if (dm_we) begin dmem[dm_addr] <= dm_wdata; dm_wr_cnt <= dm_wr_cnt + 1; end
        end else dm_wait <= dm_wait - 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected values restated from the requirements
  function automatic int x_call_fp(int sp, int p); return sp - p; endfunction
  function automatic int x_call_sp(int sp, int l); return sp + l + 2; endfunction
  function automatic int x_info(int fp, int p, int l); return fp + p + l; endfunction
  function automatic bit x_refuse(int sp, int p, int l); return (p > sp) || (sp + l + 2 > LIM); endfunction

  task automatic run_op(input logic [1:0] k, input int m, input int rpc, input int sp, input int fp);
    bit seen;
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; meth_addr = PW'(m); ret_pc = PW'(rpc);
    cur_sp = AW'(sp); cur_fp = AW'(fp);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9", "op_ready while busy", int'(op_ready), 0);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk("R9", "done reached", int'(seen), 1);
  endtask

  task automatic check_done_pulse();
    @(negedge clk);
    chk("R9", "done one cycle", int'(done), 0);
  endtask

  task automatic set_hdr(input int m, input int p, input int l);
    pmem[m] = 8'(p); pmem[m+1] = 8'(l);
  endtask

  initial begin
    int p, l, m, rpc, fp, sp, k, top, wc, nsp, nfp;
    logic [1:0] rk;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1<<AW); i++) dmem[i] = '0;
    for (int i = 0; i < (1<<PW); i++) pmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "op_ready", int'(op_ready), 1);
    chk("R1", "done", int'(done), 0);
    chk("R1", "ovf", int'(ovf), 0);
    chk("R1", "requests", int'(pm_req) + int'(dm_req), 0);
    chk("R1", "results", int'(res_sp) + int'(res_fp) + int'(res_pc), 0);

    // R10: empty code ignored
    op_valid = 1'b1; op_kind = 2'b00;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", "ready kept", int'(op_ready), 1);
      chk("R10", "no request/done", int'(pm_req) + int'(dm_req) + int'(done), 0);
    end
    op_valid = 1'b0;
    chk("R10", "result unchanged", int'(res_sp), 0);

    // R3/R4 corner: no parameters, no locals
    set_hdr(100, 0, 0);
    dmem[300] = 16'hffff; dmem[301] = 16'hffff;
    run_op(2'b01, 100, 77, 300, 250);
    chk("R3", "empty frame fp", int'(res_fp), 300);
    chk("R3", "empty frame sp", int'(res_sp), 302);
    chk("R3", "empty frame pc", int'(res_pc), 102);
    chk("R4", "empty frame ret pc word", int'(dmem[300]), 77);
    chk("R4", "empty frame fp word", int'(dmem[301]), 250);
    check_done_pulse();

    // R5 boundary: new SP equal to the limit is accepted
    set_hdr(200, 2, 5);
    run_op(2'b01, 200, 9, LIM - 7, 10);
    chk("R5", "at limit ovf", int'(ovf), 0);
    chk("R5", "at limit sp", int'(res_sp), LIM);
    // one word beyond is refused with no writes
    wc = dm_wr_cnt;
    run_op(2'b01, 200, 9, LIM - 6, 11);
    chk("R5", "past limit ovf", int'(ovf), 1);
    chk("R5", "past limit writes", dm_wr_cnt - wc, 0);
    chk("R5", "past limit sp", int'(res_sp), LIM - 6);
    chk("R5", "past limit fp", int'(res_fp), 11);
    chk("R5", "past limit pc", int'(res_pc), 9);
    // parameter count above SP is refused
    set_hdr(210, 5, 1);
    wc = dm_wr_cnt;
    run_op(2'b01, 210, 4, 3, 0);
    chk("R5", "param underflow ovf", int'(ovf), int'(x_refuse(3, 5, 1)));
    chk("R5", "param underflow writes", dm_wr_cnt - wc, 0);

    // random call / return pairs (R2, R3, R4, R6, R7)
    for (int it = 0; it < 40; it++) begin
      p = $urandom_range(0, 6); l = $urandom_range(0, 12);
      m = 2 * $urandom_range(150, 2000); rpc = $urandom_range(0, 4095);
      sp = $urandom_range(p + 200, 900); fp = $urandom_range(0, 150);
      set_hdr(m, p, l);
      run_op(2'b01, m, rpc, sp, fp);
      nfp = x_call_fp(sp, p); nsp = x_call_sp(sp, l);
      chk("R3", "call fp", int'(res_fp), nfp);
      chk("R3", "call sp", int'(res_sp), nsp);
      chk("R2", "call pc after header", int'(res_pc), (m + 2) % (1<<PW));
      chk("R3", "call ovf", int'(ovf), 0);
      chk("R4", "saved pc word", int'(dmem[x_info(nfp, p, l)]), rpc);
      chk("R4", "saved fp word", int'(dmem[x_info(nfp, p, l) + 1]), fp);
      k = $urandom_range(1, 3);
      for (int j = 0; j < k; j++) dmem[nsp + j] = DW'($urandom);
      top = int'(dmem[nsp + k - 1]);
      rk = ($urandom_range(0, 1) == 1) ? 2'b11 : 2'b10;
      run_op(rk, m, 0, nsp + k, nfp);
      chk("R6", "restored pc", int'(res_pc), rpc);
      chk("R6", "restored fp", int'(res_fp), fp);
      chk("R6", "return ovf", int'(ovf), 0);
      if (rk == 2'b11) begin
        chk("R7", "sp after value return", int'(res_sp), nfp + 1);
        chk("R7", "returned value", int'(dmem[nfp]), top);
      end else begin
        chk("R6", "sp after return", int'(res_sp), nfp);
      end
    end
    check_done_pulse();

    chk("R8", "request hold violations", hold_viol, 0);
    chk("R8", "both ports requested", dual_viol, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule